// File: doc/BRIEF.md
# Cartridge Segment Bank Mapper

This block sits between a 13-bit processor bus and two external memories: a ROM of up to 64 KB and a RAM of 32 KB. The upper 4 KB of the bus (address bit 12 set) is a window made of four 1 KB segments. Each segment shows either a 1 KB ROM bank or a 512-byte RAM bank. A RAM segment is split into two halves. Reads come from the lower half and writes go through the upper half, so both halves reach the same 512 RAM bytes.

Software changes the mapping by writing one byte to one of two hotspot addresses in the low region. That region is shared with a separate IO device. One hotspot selects ROM and the other selects RAM. The top two bits of the byte name the segment and the low six bits name the bank. The block holds the four segment registers. It also translates every window access into a ROM address, a RAM address, a RAM write enable, a RAM read select and a data-output enable for the cartridge bus driver. The memories and the IO device are outside the block.

Top module: `cartSegMapper`

## Requirements
- R1: After reset, all four segments map ROM bank 0. A read at window offset `o` (`busAddr` = $1000 + `o`) gives `dataOe`=1, `ramRd`=0 and `romAddr` = `o[9:0]`. The same holds in segment 3 ($1C00–$1FFF).
- R2: The `busData` bits 7:6 give the segment and bits 5:0 give the bank. A write with `busAddr` = $003F maps ROM bank `busData[5:0]` into that segment, starting from the next clock cycle. A read there gives `dataOe`=1, `ramRd`=0 and `romAddr` = {bank, `busAddr[9:0]`}.
- R3: A write with `busAddr` = $003E maps RAM bank `busData[5:0]` into segment `busData[7:6]`, starting from the next cycle. A read in the lower half of that segment (`busAddr[9]`=0) gives `dataOe`=1, `ramRd`=1 and `ramAddr` = {bank, `busAddr[8:0]`}.
- R4: A write to the upper half of a RAM segment (`busAddr[9]`=1) gives `ramWe`=1 and `ramAddr` = {bank, `busAddr[8:0]`}, with `dataOe`=0.
- R5: A write to the lower half of a RAM segment leaves `ramWe` at 0. A read from the upper half gives `dataOe`=0 and `ramRd`=0.
- R6: An access with `busAddr[12]`=0 never raises `dataOe`, `ramRd` or `ramWe`. Any other access leaves the mapping unchanged. This covers reads of $003E/$003F, writes to other low addresses, and writes to $103E/$103F.
- R7: A write into a ROM-mapped segment gives `ramWe`=0 and does not change any mapping.
- R8: The ROM bank number is stored modulo the parameter `ROM_BANKS`, so `romAddr[15:10]` is always below `ROM_BANKS`.
- R9: A hotspot write changes only the segment it names. The other three keep their bank and their ROM/RAM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 13 | Processor address |
| busWr | input | 1 | Write strobe for this cycle |
| busRd | input | 1 | Read strobe for this cycle |
| busData | input | 8 | Write data (hotspot mapping byte) |
| romAddr | output | 16 | External ROM address {bank, offset[9:0]} |
| ramAddr | output | 15 | External RAM address {bank, offset[8:0]} |
| ramWe | output | 1 | RAM write enable |
| ramRd | output | 1 | Read data comes from RAM instead of ROM |
| dataOe | output | 1 | Cartridge drives the data bus |

## Verification
A corrupted segment register shows up at the ports on the first window access into that segment after the fault. The symptom is a wrong high field of `romAddr` or `ramAddr`, or a wrong RAM/ROM choice that flips `ramRd`, `dataOe` or `ramWe`. A hotspot decoded on the wrong address, or a load routed to the wrong segment, is caught one cycle later by a read of the affected segments. The reference model is compared on every cycle, so the error is flagged in the cycle it first appears. Segments that are never accessed hide their state until the bench reads them, so the stimulus returns to all four segments after each remap.

// File: rtl/cartMapPkg.sv
package cartMapPkg;
  localparam int SEG_W  = 2;
  localparam int BANK_W = 6;
  localparam int NSEG   = 1 << SEG_W;

  // Mapping command decoded from a hotspot write
  typedef struct packed {
    logic              romLoad;
    logic              ramLoad;
    logic [SEG_W-1:0]  seg;
    logic [BANK_W-1:0] bank;
  } mapCmd_t;

  // Qualified window access
  typedef struct packed {
    logic inWin;
    logic upper;
    logic rd;
    logic wr;
  } busAcc_t;
endpackage

// File: rtl/mapCtrl.sv
module mapCtrl
  import cartMapPkg::*;
#(
  parameter int          ADDR_W  = 13,
  parameter int          DATA_W  = 8,
  parameter int          RAM_PW  = 9,
  parameter logic [12:0] HOT_ROM = 13'h003F,
  parameter logic [12:0] HOT_RAM = 13'h003E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busData,
  output mapCmd_t           cmd,
  output busAcc_t           acc
);
  localparam int WIN_BIT = ADDR_W - 1;

  always_comb begin
    cmd.romLoad = busWr && (busAddr == ADDR_W'(HOT_ROM));
    cmd.ramLoad = busWr && (busAddr == ADDR_W'(HOT_RAM));
    cmd.seg     = busData[DATA_W-1 -: SEG_W];
    cmd.bank    = busData[BANK_W-1:0];
    acc.inWin   = busAddr[WIN_BIT];
    acc.upper   = busAddr[RAM_PW];
    acc.rd      = busRd;
    acc.wr      = busWr;
  end

  // A hotspot load never coincides with a window access
  AST_LOAD_OUTSIDE_WIN: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.romLoad || cmd.ramLoad) |-> !acc.inWin); // R6
endmodule

// File: rtl/mapDatapath.sv
module mapDatapath
  import cartMapPkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int ROM_PW    = 10,
  parameter int RAM_PW    = 9,
  parameter int ROM_BANKS = 64,
  localparam int ROM_AW   = BANK_W + ROM_PW,
  localparam int RAM_AW   = BANK_W + RAM_PW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  mapCmd_t           cmd,
  input  busAcc_t           acc,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe,
  output logic              ramRd,
  output logic              dataOe
);
  logic [NSEG-1:0][BANK_W-1:0] segBank;
  logic [NSEG-1:0]             segRam;
  logic [BANK_W-1:0]           romBankRed;
  logic [SEG_W-1:0]            curSeg;
  logic [BANK_W-1:0]           curBank;
  logic                        curRam;

  assign romBankRed = BANK_W'(32'(cmd.bank) % ROM_BANKS);

  for (genvar g = 0; g < NSEG; g++) begin : gSeg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        segBank[g] <= '0;
        segRam[g]  <= 1'b0;
      end else if (cmd.seg == SEG_W'(g)) begin
        if (cmd.romLoad) begin
          segBank[g] <= romBankRed;
          segRam[g]  <= 1'b0;
        end else if (cmd.ramLoad) begin
          segBank[g] <= cmd.bank;
          segRam[g]  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    curSeg  = busAddr[ROM_PW +: SEG_W];
    curBank = segBank[curSeg];
    curRam  = segRam[curSeg];
    romAddr = {curBank, busAddr[ROM_PW-1:0]};
    ramAddr = {curBank, busAddr[RAM_PW-1:0]};
    ramWe   = acc.wr && acc.inWin && curRam && acc.upper;
    ramRd   = acc.rd && acc.inWin && curRam && !acc.upper;
    dataOe  = acc.rd && acc.inWin && (!curRam || !acc.upper);
  end

  AST_NO_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busAddr[ADDR_W-1] |-> !(dataOe || ramRd || ramWe)); // R6
  AST_WE_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (busAddr[RAM_PW] && !dataOe)); // R5
  AST_ROM_BANK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && !ramRd) |-> (32'(romAddr[ROM_AW-1 -: BANK_W]) < ROM_BANKS)); // R8
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.romLoad || cmd.ramLoad) |=> ($stable(segBank) && $stable(segRam))); // R7
  AST_RAMRD_IMPLIES_OE: assert property (@(posedge clk) disable iff (!rstN)
    ramRd |-> dataOe); // R3
endmodule

// File: rtl/cartSegMapper.sv
module cartSegMapper
  import cartMapPkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int ROM_PW    = 10,
  parameter int RAM_PW    = 9,
  parameter int ROM_BANKS = 64,
  localparam int ROM_AW   = BANK_W + ROM_PW,
  localparam int RAM_AW   = BANK_W + RAM_PW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe,
  output logic              ramRd,
  output logic              dataOe
);
  mapCmd_t cmd;
  busAcc_t acc;

  mapCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_PW(RAM_PW)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busData(busData), .cmd(cmd), .acc(acc)
  );

  mapDatapath #(.ADDR_W(ADDR_W), .ROM_PW(ROM_PW), .RAM_PW(RAM_PW),
                .ROM_BANKS(ROM_BANKS)) uDp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .cmd(cmd), .acc(acc),
    .romAddr(romAddr), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramRd(ramRd), .dataOe(dataOe)
  );
endmodule

// File: tb/sim_cartSegMapper.sv
`timescale 1ns/1ps
module sim_cartSegMapper;
  localparam int ROMB = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busData = '0;
  logic [15:0] romAddr;
  logic [14:0] ramAddr;
  logic        ramWe, ramRd, dataOe;

  int tests = 0, fails = 0;
  bit done = 0;
  int refBank[4];
  bit refRam[4];

  always #2 clk = ~clk;

  cartSegMapper #(.ROM_BANKS(ROMB)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busData(busData), .romAddr(romAddr), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramRd(ramRd), .dataOe(dataOe)
  );

  task automatic step(input logic [12:0] a, input bit w, input bit r,
                      input logic [7:0] d, input string tag);
    int seg;
    bit ram, eWe, eRd, eOe, ok;
    logic [15:0] eRom;
    logic [14:0] eRam;
    @(negedge clk);
    busAddr = a; busWr = w; busRd = r; busData = d;
    #1;
    seg  = int'(a[11:10]);
    ram  = refRam[seg];
    eWe  = w && a[12] && ram && a[9];
    eRd  = r && a[12] && ram && !a[9];
    eOe  = r && a[12] && (!ram || !a[9]);
    eRom = {6'(refBank[seg]), a[9:0]};
    eRam = {6'(refBank[seg]), a[8:0]};
    ok = (ramWe == eWe) && (ramRd == eRd) && (dataOe == eOe) &&
         (!(eOe && !eRd) || romAddr == eRom) &&
         (!(eRd || eWe) || ramAddr == eRam);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s addr=%h: got we=%b rd=%b oe=%b rom=%h ram=%h exp we=%b rd=%b oe=%b rom=%h ram=%h",
               tag, a, ramWe, ramRd, dataOe, romAddr, ramAddr, eWe, eRd, eOe, eRom, eRam);
    end
    @(posedge clk);
    if (rstN && w && a == 13'h003F) begin
      refRam[int'(d[7:6])] = 0; refBank[int'(d[7:6])] = int'(d[5:0]) % ROMB;
    end else if (rstN && w && a == 13'h003E) begin
      refRam[int'(d[7:6])] = 1; refBank[int'(d[7:6])] = int'(d[5:0]);
    end
  endtask

  task automatic rd(input logic [12:0] a, input string tag); step(a, 0, 1, 8'h00, tag); endtask
  task automatic wr(input logic [12:0] a, input logic [7:0] d, input string tag); step(a, 1, 0, d, tag); endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin refBank[i] = 0; refRam[i] = 0; end
    rd(13'h1C05, "R1 in reset");
    @(negedge clk); rstN = 1'b1;
    rd(13'h1C05, "R1 seg3"); rd(13'h1000, "R1 seg0");
    rd(13'h17FF, "R1 seg1"); rd(13'h1BFF, "R1 seg2");
    wr(13'h003F, {2'd1, 6'd7}, "R2 load");
    rd(13'h1523, "R2 rom bank7"); rd(13'h1010, "R9 seg0 kept");
    wr(13'h003F, {2'd3, 6'd45}, "R8 load");
    rd(13'h1FFF, "R8 modulo");
    wr(13'h003E, {2'd2, 6'd9}, "R3 load");
    rd(13'h19AB, "R3 ram read"); rd(13'h1523, "R9 seg1 kept");
    wr(13'h1A05, 8'h5A, "R4 ram write");
    wr(13'h1805, 8'hA5, "R5 write read half");
    rd(13'h1A10, "R5 read write half");
    rd(13'h003F, "R6 read hotspot"); wr(13'h003D, 8'h41, "R6 other low");
    wr(13'h007F, 8'h83, "R6 other low");
    wr(13'h103F, 8'hC1, "R6 window hotspot alias");
    rd(13'h003E, "R6 read ram hotspot");
    rd(13'h1C00, "R6 seg3 kept"); rd(13'h1800, "R6 seg2 kept");
    wr(13'h1400, 8'hFF, "R7 rom write"); rd(13'h1401, "R7 seg1 kept");
    wr(13'h003E, {2'd0, 6'd63}, "R3 load seg0");
    wr(13'h13FF, 8'h11, "R4 top byte"); rd(13'h11FF, "R3 seg0 read");
    wr(13'h003F, {2'd2, 6'd39}, "R2 back to rom");
    rd(13'h1BFF, "R2 rom bank39"); wr(13'h1BFF, 8'h00, "R7 rom write");
    step(13'h1A00, 0, 0, 8'h00, "R6 idle");
    for (int i = 0; i < 64; i++) begin
      wr((i % 3 == 0) ? 13'h003E : 13'h003F, 8'((i * 37) ^ (i << 6)), "R9 sweep load");
      for (int s = 0; s < 4; s++) begin
        rd(13'(13'h1000 + s * 13'h400 + (i * 11) % 512), "R9 sweep read lo");
        rd(13'(13'h1200 + s * 13'h400 + (i * 5) % 512), "R5 sweep read hi");
        wr(13'(13'h1200 + s * 13'h400 + i), 8'(i), "R4 sweep write");
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule